// File: doc/BRIEF.md
# Stop-Mode Wake Source Controller

This block decides when a microcontroller core that has stopped its clock tree for low power is allowed to resume, and what kind of restart follows. Software programs a small control register that names one port pin or one NOR-combined group of port-2 pins as the primary wake source. A second, separate group selector can also wake the core. One polarity bit sets whether a high or a low level counts as active for both selectors. A delay-enable bit chooses between two restart styles. In the first, the wake also asks for the full power-on reset delay. In the second, the fast style, the source must stay active for a minimum number of clock periods before the wake is accepted.

The core pulses a stop-entry strobe when it stops. From then on the block watches the synchronized pins, and it issues a one-cycle wake request once the selected source qualifies. A status bit records whether the last restart was warm, after a stop, or cold, after a power-on or watchdog reset. While a port-2 pin is driven as an output, the block watches the level the port drives rather than the pad.

Top module: `stop_wake_ctl`

## Requirements
- R1: After power-on reset the readback shows source code 0, polarity 0, delay-enable 1 and group code 0, the warm bit reads 0, and wake_req and dly_req are low.
- R2: Source codes 1, 2, 3 and 4 select p3_pin bits 0, 1, 2 and 3. Code 5 selects p2 bit 7. Code 6 selects the NOR of p2 bits 3..0, and code 7 selects the NOR of p2 bits 7..0. Pins that are not selected have no effect.
- R3: While p3_ana is 1, sources 2, 3 and 4 never wake the core. Source 1 is not affected by p3_ana.
- R4: With polarity 1 the selected source is active when its level is 1. With polarity 0 it is active when its level is 0. The same polarity applies to the group selector.
- R5: With delay-enable 1, a source that becomes active while stopped raises wake_req and dly_req together for one cycle, on the third rising edge after the pin changes (two synchronizer stages plus one output register).
- R6: With delay-enable 0, a wake needs the source active on 5 consecutive synchronized cycles. A 4-cycle pulse produces no wake. A 5-cycle pulse raises wake_req on the seventh edge after the pin changes, and dly_req stays low.
- R7: The warm bit is set by stop_enter and stays set through a wake. It is cleared by power-on reset or wdt_rst.
- R8: For every p2 bit whose p2_dir is 1 (output), the wake logic uses p2_out in place of p2_pin.
- R9: Group codes 1, 2 and 3 select the NOR of p2 bits 3..0, 7..0 and 7..4. Group code 0 is off. The group wakes the core independently of the source code.
- R10: Wake is issued only while stopped. A wake clears the stopped state, so wake_req is a one-cycle pulse. wdt_rst also clears the stopped state.
- R11: Control writes are ignored while stopped. After a wake they take effect.
- R12: With source code 0 and group code 0, no pin activity ever wakes the core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, active high, asynchronous |
| wdt_rst | input | 1 | Watchdog reset, active high, synchronous |
| cfg_we | input | 1 | Control register write strobe |
| cfg_src | input | 3 | Source code to write |
| cfg_pol | input | 1 | Polarity to write |
| cfg_dly | input | 1 | Delay-enable to write |
| cfg_grp | input | 2 | Group code to write |
| p3_pin | input | 4 | Port-3 pins 0..3 |
| p3_ana | input | 1 | Port-3 pins 1..3 in analog mode |
| p2_pin | input | 8 | Port-2 pad levels |
| p2_dir | input | 8 | Port-2 direction, 1 = output |
| p2_out | input | 8 | Port-2 output latch |
| stop_enter | input | 1 | Stop-mode entry strobe |
| rd_src | output | 3 | Source code readback |
| rd_pol | output | 1 | Polarity readback |
| rd_dly | output | 1 | Delay-enable readback |
| rd_grp | output | 2 | Group code readback |
| warm | output | 1 | 1 = last restart was a stop wake |
| wake_req | output | 1 | One-cycle wake pulse |
| dly_req | output | 1 | Full reset delay request, pulses with wake_req |

## Verification
Each source code is tried by first raising every pin except the selected one, which shows whether the decoder picks the right pin. The two NOR codes are tried with patterns that differ only in the upper nibble, which separates the 4-pin group from the 8-pin group. The fast style is tried with a 4-cycle pulse and with a 5-cycle pulse, which pins the qualification boundary exactly. Output-mode port-2 pins are tried with pads and latch at opposite levels, and analog mode, polarity and the locked register each get their own pattern.

// File: rtl/stop_wake_ctl.sv
`timescale 1ns/1ps
module stop_wake_ctl #(
  parameter int HOLD = 5
) (
  input  logic       clk,
  input  logic       rst_por,
  input  logic       wdt_rst,
  input  logic       cfg_we,
  input  logic [2:0] cfg_src,
  input  logic       cfg_pol,
  input  logic       cfg_dly,
  input  logic [1:0] cfg_grp,
  input  logic [3:0] p3_pin,
  input  logic       p3_ana,
  input  logic [7:0] p2_pin,
  input  logic [7:0] p2_dir,
  input  logic [7:0] p2_out,
  input  logic       stop_enter,
  output logic [2:0] rd_src,
  output logic       rd_pol,
  output logic       rd_dly,
  output logic [1:0] rd_grp,
  output logic       warm,
  output logic       wake_req,
  output logic       dly_req
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [11:0] s1, s2;
  logic [CW-1:0] cnt;
  logic stopped, src_lvl, src_ok, grp_lvl, grp_ok;

  wire [11:0] raw = {(p2_dir & p2_out) | (~p2_dir & p2_pin), p3_pin};
  wire [3:0]  p3  = s2[3:0];
  wire [7:0]  p2  = s2[11:4];

  always_ff @(posedge clk or posedge rst_por)
    if (rst_por) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  always_comb begin
    src_lvl = 1'b0;
    src_ok  = 1'b1;
    case (rd_src)
      3'd1: src_lvl = p3[0];
      3'd2: begin src_lvl = p3[1]; src_ok = !p3_ana; end
      3'd3: begin src_lvl = p3[2]; src_ok = !p3_ana; end
      3'd4: begin src_lvl = p3[3]; src_ok = !p3_ana; end
      3'd5: src_lvl = p2[7];
      3'd6: src_lvl = ~|p2[3:0];
      3'd7: src_lvl = ~|p2;
      default: src_ok = 1'b0;
    endcase
  end

  always_comb begin
    grp_ok = 1'b1;
    case (rd_grp)
      2'd1:    grp_lvl = ~|p2[3:0];
      2'd2:    grp_lvl = ~|p2;
      2'd3:    grp_lvl = ~|p2[7:4];
      default: begin grp_lvl = 1'b0; grp_ok = 1'b0; end
    endcase
  end

  wire active = (src_ok && (src_lvl == rd_pol)) || (grp_ok && (grp_lvl == rd_pol));
  wire fire   = stopped && active && (rd_dly || cnt == LAST);

  always_ff @(posedge clk or posedge rst_por)
    if (rst_por)                cnt <= '0;
    else if (!stopped || !active) cnt <= '0;
    else if (cnt != LAST)       cnt <= cnt + 1'b1;

  always_ff @(posedge clk or posedge rst_por)
    if (rst_por) begin
      stopped  <= 1'b0;
      warm     <= 1'b0;
      wake_req <= 1'b0;
      dly_req  <= 1'b0;
    end else begin
      wake_req <= fire && !wdt_rst;
      dly_req  <= fire && rd_dly && !wdt_rst;
      if (wdt_rst) begin
        stopped <= 1'b0;
        warm    <= 1'b0;
      end else if (stop_enter) begin
        stopped <= 1'b1;
        warm    <= 1'b1;
      end else if (fire) begin
        stopped <= 1'b0;
      end
    end

  always_ff @(posedge clk or posedge rst_por)
    if (rst_por) begin
      rd_src <= 3'd0;
      rd_pol <= 1'b0;
      rd_dly <= 1'b1;
      rd_grp <= 2'd0;
    end else if (cfg_we && !stopped) begin
      rd_src <= cfg_src;
      rd_pol <= cfg_pol;
      rd_dly <= cfg_dly;
      rd_grp <= cfg_grp;
    end

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst_por)
    wake_req |=> !wake_req);
  p_stop_clear_r10: assert property (@(posedge clk) disable iff (rst_por)
    wake_req |-> !stopped);
  p_dly_with_wake_r5: assert property (@(posedge clk) disable iff (rst_por)
    dly_req |-> wake_req);
  p_fast_hold_r6: assert property (@(posedge clk) disable iff (rst_por)
    (wake_req && !dly_req) |-> $past(cnt) == LAST);
  p_frozen_r11: assert property (@(posedge clk) disable iff (rst_por)
    stopped |=> $stable({rd_src, rd_pol, rd_dly, rd_grp}));
  p_warm_set_r7: assert property (@(posedge clk) disable iff (rst_por)
    (stop_enter && !wdt_rst) |=> warm);
  p_cold_r7: assert property (@(posedge clk) disable iff (rst_por)
    wdt_rst |=> (!warm && !wake_req));
  p_analog_r3: assert property (@(posedge clk) disable iff (rst_por)
    (wake_req && $past(p3_ana) && $past(rd_grp) == 2'd0) |-> !($past(rd_src) inside {3'd2, 3'd3, 3'd4}));
  p_code0_r12: assert property (@(posedge clk) disable iff (rst_por)
    (rd_src == 3'd0 && rd_grp == 2'd0) |=> !wake_req);
endmodule

// File: tb/stop_wake_ctl_tb.sv
`timescale 1ns/1ps
module stop_wake_ctl_tb;
  logic clk = 0, rst_por = 1, wdt_rst = 0, cfg_we = 0, cfg_pol = 0, cfg_dly = 0;
  logic [2:0] cfg_src = 0;
  logic [1:0] cfg_grp = 0;
  logic [3:0] p3_pin = 0;
  logic p3_ana = 0, stop_enter = 0;
  logic [7:0] p2_pin = 0, p2_dir = 0, p2_out = 0;
  logic [2:0] rd_src;
  logic rd_pol, rd_dly, warm, wake_req, dly_req;
  logic [1:0] rd_grp;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stop_wake_ctl u_dut (
    .clk(clk), .rst_por(rst_por), .wdt_rst(wdt_rst), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_pol(cfg_pol), .cfg_dly(cfg_dly), .cfg_grp(cfg_grp), .p3_pin(p3_pin), .p3_ana(p3_ana),
    .p2_pin(p2_pin), .p2_dir(p2_dir), .p2_out(p2_out), .stop_enter(stop_enter),
    .rd_src(rd_src), .rd_pol(rd_pol), .rd_dly(rd_dly), .rd_grp(rd_grp), .warm(warm),
    .wake_req(wake_req), .dly_req(dly_req));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(logic [2:0] s, logic p, logic d, logic [1:0] g);
    @(negedge clk);
    cfg_we = 1; cfg_src = s; cfg_pol = p; cfg_dly = d; cfg_grp = g;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic enter_stop();
    @(negedge clk); stop_enter = 1;
    @(negedge clk); stop_enter = 0;
  endtask

  task automatic setup(logic [2:0] s, logic p, logic d, logic [1:0] g,
                       logic [3:0] p3v, logic [7:0] p2v, bit do_stop);
    @(negedge clk);
    p3_pin = p3v; p2_pin = p2v; p2_dir = 0; p2_out = 0; p3_ana = 0; wdt_rst = 0;
    rst_por = 1;
    @(negedge clk);
    rst_por = 0;
    write_cfg(s, p, d, g);
    repeat (4) @(negedge clk);
    if (do_stop) enter_stop();
  endtask

  task automatic expect_wake(int n, logic dexp, string tag);
    int early = 0;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (wake_req) early++;
    end
    @(negedge clk);
    chk({tag, " no early wake"}, early, 0);
    chk({tag, " wake_req"}, wake_req, 1);
    chk({tag, " dly_req"}, dly_req, dexp);
  endtask

  task automatic expect_quiet(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wake_req) seen++;
    end
    chk({tag, " quiet"}, seen, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 src", rd_src, 0); chk("R1 pol", rd_pol, 0); chk("R1 dly", rd_dly, 1);
    chk("R1 grp", rd_grp, 0); chk("R1 warm", warm, 0);
    chk("R1 wake", wake_req, 0); chk("R1 dlyreq", dly_req, 0);
  endtask

  task automatic t_sources();
    for (int c = 1; c <= 5; c++) begin
      setup(3'(c), 1, 1, 0, 4'h0, 8'h00, 1);
      if (c == 5) begin p3_pin = 4'hF; p2_pin = 8'h7F; end
      else p3_pin = ~(4'b1 << (c - 1));
      expect_quiet(6, "R2 other pins");
      if (c == 5) p2_pin = 8'hFF; else p3_pin = 4'hF;
      expect_wake(3, 1, "R2 R5 selected pin");
    end
    setup(3'd6, 1, 1, 0, 4'h0, 8'hFF, 1);
    p2_pin = 8'h0F;
    expect_quiet(6, "R2 nor-low upper zero");
    p2_pin = 8'hF0;
    expect_wake(3, 1, "R2 nor-low");
    setup(3'd7, 1, 1, 0, 4'h0, 8'hFF, 1);
    p2_pin = 8'h80;
    expect_quiet(6, "R2 nor-all bit7 high");
    p2_pin = 8'h00;
    expect_wake(3, 1, "R2 nor-all");
  endtask

  task automatic t_analog();
    for (int c = 2; c <= 4; c++) begin
      setup(3'(c), 1, 1, 0, 4'h0, 8'h00, 0);
      p3_ana = 1;
      enter_stop();
      p3_pin = 4'hF;
      expect_quiet(8, "R3 analog blocks");
      p3_ana = 0;
      expect_wake(1, 1, "R3 analog released");
    end
    setup(3'd1, 1, 1, 0, 4'h0, 8'h00, 0);
    p3_ana = 1;
    enter_stop();
    p3_pin = 4'h1;
    expect_wake(3, 1, "R3 pin0 unaffected");
  endtask

  task automatic t_polarity();
    setup(3'd1, 0, 1, 0, 4'h1, 8'h00, 1);
    expect_quiet(6, "R4 high idle with pol0");
    p3_pin = 4'h0;
    expect_wake(3, 1, "R4 low wakes");
  endtask

  task automatic t_fast();
    setup(3'd1, 1, 0, 0, 4'h0, 8'h00, 1);
    p3_pin = 4'h1;
    repeat (4) @(negedge clk);
    p3_pin = 4'h0;
    expect_quiet(12, "R6 four-cycle pulse");
    p3_pin = 4'h1;
    expect_wake(7, 0, "R6 five-cycle hold");
  endtask

  task automatic t_warm();
    setup(3'd1, 1, 1, 0, 4'h0, 8'h00, 1);
    chk("R7 warm after stop", warm, 1);
    p3_pin = 4'h1;
    expect_wake(3, 1, "R7 wake");
    @(negedge clk);
    chk("R7 warm kept", warm, 1);
    p3_pin = 4'h0;
    repeat (4) @(negedge clk);
    enter_stop();
    wdt_rst = 1;
    @(negedge clk);
    wdt_rst = 0;
    chk("R7 wdt cold", warm, 0);
    p3_pin = 4'h1;
    expect_quiet(8, "R10 wdt clears stop");
    setup(3'd0, 0, 1, 0, 4'h0, 8'h00, 1);
    chk("R7 warm set", warm, 1);
    rst_por = 1;
    @(negedge clk);
    rst_por = 0;
    chk("R7 por cold", warm, 0);
  endtask

  task automatic t_port2_out();
    setup(3'd6, 1, 1, 0, 4'h0, 8'h00, 0);
    p2_dir = 8'h0F; p2_out = 8'h0F;
    repeat (4) @(negedge clk);
    enter_stop();
    expect_quiet(6, "R8 driven high overrides low pads");
    p2_pin = 8'hFF; p2_out = 8'h00;
    expect_wake(3, 1, "R8 driven low wakes");
  endtask

  task automatic t_group();
    setup(3'd0, 1, 1, 2'd1, 4'h0, 8'hFF, 1);
    p2_pin = 8'h0F;
    expect_quiet(5, "R9 grp1 low nibble high");
    p2_pin = 8'hF0;
    expect_wake(3, 1, "R9 grp1");
    setup(3'd0, 1, 1, 2'd2, 4'h0, 8'hFF, 1);
    p2_pin = 8'h80;
    expect_quiet(5, "R9 grp2 bit7 high");
    p2_pin = 8'h00;
    expect_wake(3, 1, "R9 grp2");
    setup(3'd0, 1, 1, 2'd3, 4'h0, 8'hFF, 1);
    p2_pin = 8'hF0;
    expect_quiet(5, "R9 grp3 upper high");
    p2_pin = 8'h0F;
    expect_wake(3, 1, "R9 grp3");
    setup(3'd0, 0, 1, 2'd1, 4'h0, 8'h00, 1);
    expect_quiet(5, "R4 R9 pol0 all low idle");
    p2_pin = 8'h04;
    expect_wake(3, 1, "R4 R9 pol0 group");
  endtask

  task automatic t_not_stopped();
    setup(3'd1, 1, 1, 0, 4'h0, 8'h00, 0);
    p3_pin = 4'h1;
    expect_quiet(8, "R10 not stopped");
    p3_pin = 4'h0;
    repeat (4) @(negedge clk);
    enter_stop();
    p3_pin = 4'h1;
    expect_wake(3, 1, "R10 stopped wake");
    @(negedge clk);
    chk("R10 single pulse", wake_req, 0);
    expect_quiet(6, "R10 cleared after wake");
  endtask

  task automatic t_write_lock();
    setup(3'd1, 1, 1, 0, 4'h0, 8'h00, 1);
    write_cfg(3'd3, 0, 0, 2'd2);
    chk("R11 src locked", rd_src, 1); chk("R11 pol locked", rd_pol, 1);
    chk("R11 dly locked", rd_dly, 1); chk("R11 grp locked", rd_grp, 0);
    p3_pin = 4'h1;
    expect_wake(3, 1, "R11 old cfg wakes");
    write_cfg(3'd3, 0, 0, 2'd2);
    chk("R11 src after wake", rd_src, 3); chk("R11 grp after wake", rd_grp, 2);
  endtask

  task automatic t_code0();
    setup(3'd0, 1, 1, 0, 4'h0, 8'h00, 1);
    p3_pin = 4'hF; p2_pin = 8'hFF;
    expect_quiet(5, "R12 all high");
    p3_pin = 4'h0; p2_pin = 8'h00;
    expect_quiet(5, "R12 all low");
    write_cfg(3'd0, 0, 0, 0);
    expect_quiet(8, "R12 pol0 fast");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_por = 0;
    t_reset();
    t_sources();
    t_analog();
    t_polarity();
    t_fast();
    t_warm();
    t_port2_out();
    t_group();
    t_not_stopped();
    t_write_lock();
    t_code0();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule